// File: doc/BRIEF.md
# SMI Status Aggregation Register

This block gathers power-management event sources into one 32-bit status word that firmware reads to find out why a System Management Interrupt was requested. Two of its bits are sticky. One latches an I/O access to the embedded-controller ports 0x62 or 0x66 while the controller decode is enabled. The other latches the expiry pulse of the software SMI timer. Each sticky bit stays at 1 until software writes a 1 to its position.

The other defined bits are not stored. Each one is recomputed every cycle from status and enable vectors that other event registers own. There are three masked OR summaries: the alternate GPI events, the GPE0 events and the PM1 events. A fourth live bit mirrors bit 0 of the device-trap status.

Only the sticky bits, each qualified by its own enable input, can raise the registered SMI request. The summary bits only report status.

Top module: `smi_evt_status`

## Requirements
- R1: After reset, every bit of `rd_data` reads 0 and `smi_req` is 0.
- R2: Bit 11 (controller access) sets on the clock edge where `io_acc_vld` is 1, `io_acc_port` is 0x62 or 0x66 and `ucon_dec_en` is 1. Any other port, or a decode enable of 0, leaves it unchanged.
- R3: Writing with bit 11 or bit 6 of `reg_wr_data` at 1 clears that sticky bit at the next edge. Writing 0 to that position keeps its value.
- R4: If a hardware set event and a write-1-to-clear hit the same sticky bit in one cycle, the bit ends at 1.
- R5: Bit 6 (software timer) sets on the edge where `swtmr_expire` is 1 and then holds at 1 until it is cleared.
- R6: `smi_req` equals, one cycle later, (bit 11 AND `ucon_smi_en`) OR (bit 6 AND `swtmr_smi_en`).
- R7: Bit 10 is live and equals the OR over i of `alt_gpi_sts[i] & alt_gpi_en[i] & alt_gpi_route[i]`. Writes have no effect on it.
- R8: Bit 9 is live and equals the OR of `gpe0_sts[i] & gpe0_en[i]` over i in {0, 3, 4, 6, 7, 8, 11, 13}. No other GPE0 bit, including bits 31:16, contributes.
- R9: Bit 8 is live and equals the OR of every `pm1_sts` bit except bits 4 and 5. Writes have no effect on it.
- R10: Bits 8, 9 and 10 never raise `smi_req` on their own.
- R11: Bit 12 is live and equals `devtrap_bit0`. Writes have no effect on it.
- R12: Every bit outside 6 and 8 through 12 reads 0, and writing 1 to those bits has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_acc_vld | input | 1 | I/O access strobe |
| io_acc_port | input | 16 | Port address of the I/O access |
| ucon_dec_en | input | 1 | Controller port decode enable |
| reg_wr_en | input | 1 | Write strobe for this register |
| reg_wr_data | input | 32 | Write data, 1 clears a sticky bit |
| swtmr_expire | input | 1 | Software SMI timer expiry pulse |
| ucon_smi_en | input | 1 | SMI enable for bit 11 |
| swtmr_smi_en | input | 1 | SMI enable for bit 6 |
| gpe0_sts | input | 32 | GPE0 status vector |
| gpe0_en | input | 32 | GPE0 enable vector |
| pm1_sts | input | 16 | PM1 status vector |
| alt_gpi_sts | input | 16 | Alternate GPI status vector |
| alt_gpi_en | input | 16 | Alternate GPI SMI enable vector |
| alt_gpi_route | input | 16 | Alternate GPI routed-to-SMI mask |
| devtrap_bit0 | input | 1 | Bit 0 of device-trap status |
| rd_data | output | 32 | Register read value |
| smi_req | output | 1 | Registered SMI request |

## Verification
The hardest situation to reach is the collision in a single cycle between a hardware set and a software clear on the same sticky bit. The stimulus drives a matching port access, or a timer pulse, together with a write-1-to-clear in the same half-period, then reads the bit back. The masked summaries are checked by sweeping one status bit at a time through every position, under every enable and route combination. The port decoder is checked by sweeping a window of addresses around 0x62 and 0x66, with the decode enable both off and on.

// File: rtl/smi_evt_pkg.sv
package smi_evt_pkg;
   localparam int unsigned REG_W        = 32;
   localparam int unsigned BIT_SWTMR    = 6;
   localparam int unsigned BIT_PM1      = 8;
   localparam int unsigned BIT_GPE0     = 9;
   localparam int unsigned BIT_GPE1     = 10;
   localparam int unsigned BIT_UCON     = 11;
   localparam int unsigned BIT_DEVMON   = 12;
   localparam int unsigned NUM_STICKY   = 2;
   localparam int unsigned STK_UCON     = 0;
   localparam int unsigned STK_SWTMR    = 1;

   typedef logic [REG_W-1:0] reg_word_t;

   function automatic int unsigned sticky_pos(input int unsigned idx);
      return (idx == STK_UCON) ? BIT_UCON : BIT_SWTMR;
   endfunction
endpackage

// File: rtl/smi_port_hit.sv
module smi_port_hit #(
   parameter int unsigned          ADDR_W = 16,
   parameter logic [ADDR_W-1:0]    PORT_A = 'h62,
   parameter logic [ADDR_W-1:0]    PORT_B = 'h66
) (
   input  logic              acc_vld,
   input  logic [ADDR_W-1:0] acc_port,
   input  logic              dec_en,
   output logic              hit
);
   if (ADDR_W < 8) begin : g_bad_addr
      $error("smi_port_hit: ADDR_W must be at least 8");
   end

   logic match_a;
   logic match_b;

   assign match_a = (acc_port == PORT_A);
   assign match_b = (acc_port == PORT_B);
   assign hit     = acc_vld & dec_en & (match_a | match_b);
endmodule

// File: rtl/smi_sticky_bit.sv
module smi_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_next;

   // the set term is ORed in after the clear, so a collision leaves the bit at 1
   assign q_next = set_i | (q_o & ~clr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= q_next;
   end
endmodule

// File: rtl/smi_masked_or.sv
module smi_masked_or #(
   parameter int unsigned   W         = 16,
   parameter logic [W-1:0]  INCL_MASK = '1,
   parameter bit            USE_GATE  = 1'b1
) (
   input  logic [W-1:0] sts,
   input  logic [W-1:0] en_a,
   input  logic [W-1:0] en_b,
   output logic         any_o
);
   if (W < 1) begin : g_bad_w
      $error("smi_masked_or: W must be nonzero");
   end

   logic [W-1:0] qual;

   if (USE_GATE) begin : g_gated
      assign qual = sts & en_a & en_b;
   end else begin : g_plain
      logic [W-1:0] unused_gate;
      assign unused_gate = en_a & en_b;
      assign qual        = sts | (unused_gate & '0);
   end

   assign any_o = |(qual & INCL_MASK);
endmodule

// File: rtl/smi_evt_status.sv
module smi_evt_status
   import smi_evt_pkg::*;
#(
   parameter int unsigned        ADDR_W        = 16,
   parameter int unsigned        GPE0_W        = 32,
   parameter int unsigned        PM1_W         = 16,
   parameter int unsigned        GPI_W         = 16,
   parameter logic [ADDR_W-1:0]  UCON_PORT_A   = 'h62,
   parameter logic [ADDR_W-1:0]  UCON_PORT_B   = 'h66,
   parameter logic [GPE0_W-1:0]  GPE0_SMI_MASK = 'h29D9,
   parameter logic [PM1_W-1:0]   PM1_SMI_MASK  = 'hFFCF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_acc_vld,
   input  logic [ADDR_W-1:0] io_acc_port,
   input  logic              ucon_dec_en,
   input  logic              reg_wr_en,
   input  logic [REG_W-1:0]  reg_wr_data,
   input  logic              swtmr_expire,
   input  logic              ucon_smi_en,
   input  logic              swtmr_smi_en,
   input  logic [GPE0_W-1:0] gpe0_sts,
   input  logic [GPE0_W-1:0] gpe0_en,
   input  logic [PM1_W-1:0]  pm1_sts,
   input  logic [GPI_W-1:0]  alt_gpi_sts,
   input  logic [GPI_W-1:0]  alt_gpi_en,
   input  logic [GPI_W-1:0]  alt_gpi_route,
   input  logic              devtrap_bit0,
   output logic [REG_W-1:0]  rd_data,
   output logic              smi_req
);
   if (GPE0_W < 14) begin : g_bad_gpe0
      $error("smi_evt_status: GPE0_W must cover bit 13");
   end
   if (PM1_W < 6) begin : g_bad_pm1
      $error("smi_evt_status: PM1_W must cover bits 5:4");
   end
   if (GPI_W < 1) begin : g_bad_gpi
      $error("smi_evt_status: GPI_W must be nonzero");
   end

   logic                  ucon_hit;
   logic [NUM_STICKY-1:0] stk_set;
   logic [NUM_STICKY-1:0] stk_clr;
   logic [NUM_STICKY-1:0] stk_q;
   logic [NUM_STICKY-1:0] stk_en;
   logic                  gpe1_any;
   logic                  gpe0_any;
   logic                  pm1_any;
   logic                  smi_next;

   smi_port_hit #(
      .ADDR_W (ADDR_W),
      .PORT_A (UCON_PORT_A),
      .PORT_B (UCON_PORT_B)
   ) u_port_hit (
      .acc_vld  (io_acc_vld),
      .acc_port (io_acc_port),
      .dec_en   (ucon_dec_en),
      .hit      (ucon_hit)
   );

   assign stk_set[STK_UCON]  = ucon_hit;
   assign stk_set[STK_SWTMR] = swtmr_expire;
   assign stk_en[STK_UCON]   = ucon_smi_en;
   assign stk_en[STK_SWTMR]  = swtmr_smi_en;

   for (genvar s = 0; s < NUM_STICKY; s++) begin : g_sticky
      localparam int unsigned POS = sticky_pos(s);
      assign stk_clr[s] = reg_wr_en & reg_wr_data[POS];
      smi_sticky_bit u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (stk_set[s]),
         .clr_i (stk_clr[s]),
         .q_o   (stk_q[s])
      );
   end

   smi_masked_or #(
      .W         (GPI_W),
      .INCL_MASK ({GPI_W{1'b1}}),
      .USE_GATE  (1'b1)
   ) u_gpe1_or (
      .sts   (alt_gpi_sts),
      .en_a  (alt_gpi_en),
      .en_b  (alt_gpi_route),
      .any_o (gpe1_any)
   );

   smi_masked_or #(
      .W         (GPE0_W),
      .INCL_MASK (GPE0_SMI_MASK),
      .USE_GATE  (1'b1)
   ) u_gpe0_or (
      .sts   (gpe0_sts),
      .en_a  (gpe0_en),
      .en_b  ({GPE0_W{1'b1}}),
      .any_o (gpe0_any)
   );

   smi_masked_or #(
      .W         (PM1_W),
      .INCL_MASK (PM1_SMI_MASK),
      .USE_GATE  (1'b0)
   ) u_pm1_or (
      .sts   (pm1_sts),
      .en_a  ({PM1_W{1'b1}}),
      .en_b  ({PM1_W{1'b1}}),
      .any_o (pm1_any)
   );

   always_comb begin
      rd_data             = '0;
      rd_data[BIT_UCON]   = stk_q[STK_UCON];
      rd_data[BIT_SWTMR]  = stk_q[STK_SWTMR];
      rd_data[BIT_GPE1]   = gpe1_any;
      rd_data[BIT_GPE0]   = gpe0_any;
      rd_data[BIT_PM1]    = pm1_any;
      rd_data[BIT_DEVMON] = devtrap_bit0;
   end

   assign smi_next = |(stk_q & stk_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smi_req <= 1'b0;
      else        smi_req <= smi_next;
   end
endmodule

// File: rtl/smi_evt_status_chk.sv
module smi_evt_status_chk #(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_acc_vld,
   input logic [ADDR_W-1:0] io_acc_port,
   input logic              ucon_dec_en,
   input logic              reg_wr_en,
   input logic [31:0]       reg_wr_data,
   input logic              swtmr_expire,
   input logic              ucon_smi_en,
   input logic              swtmr_smi_en,
   input logic [31:0]       rd_data,
   input logic              smi_req
);
   logic ucon_evt;
   assign ucon_evt = io_acc_vld && ucon_dec_en &&
                     (io_acc_port == ADDR_W'('h62) || io_acc_port == ADDR_W'('h66));

   assert_ucon_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ucon_evt |=> rd_data[11]);

   assert_ucon_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_wr_data[11] && !ucon_evt) |=> !rd_data[11]);

   assert_ucon_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[11] && !(reg_wr_en && reg_wr_data[11])) |=> rd_data[11]);

   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (swtmr_expire && reg_wr_en && reg_wr_data[6]) |=> rd_data[6]);

   assert_swtmr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      swtmr_expire |=> rd_data[6]);

   assert_smi_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_data[11] && ucon_smi_en) || (rd_data[6] && swtmr_smi_en)) |=> smi_req);

   assert_summary_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(rd_data[11] && ucon_smi_en) && !(rd_data[6] && swtmr_smi_en)) |=> !smi_req);

   assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & 32'hFFFF_E0BF) == 32'h0);
endmodule

bind smi_evt_status smi_evt_status_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .io_acc_vld   (io_acc_vld),
   .io_acc_port  (io_acc_port),
   .ucon_dec_en  (ucon_dec_en),
   .reg_wr_en    (reg_wr_en),
   .reg_wr_data  (reg_wr_data),
   .swtmr_expire (swtmr_expire),
   .ucon_smi_en  (ucon_smi_en),
   .swtmr_smi_en (swtmr_smi_en),
   .rd_data      (rd_data),
   .smi_req      (smi_req)
);

// File: tb/tb_smi_evt_status.sv
`timescale 1ns/1ps
module tb_smi_evt_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_acc_vld = 1'b0;
   logic [15:0] io_acc_port = '0;
   logic        ucon_dec_en = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic        swtmr_expire = 1'b0;
   logic        ucon_smi_en = 1'b0;
   logic        swtmr_smi_en = 1'b0;
   logic [31:0] gpe0_sts = '0;
   logic [31:0] gpe0_en = '0;
   logic [15:0] pm1_sts = '0;
   logic [15:0] alt_gpi_sts = '0;
   logic [15:0] alt_gpi_en = '0;
   logic [15:0] alt_gpi_route = '0;
   logic        devtrap_bit0 = 1'b0;
   logic [31:0] rd_data;
   logic        smi_req;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   smi_evt_status dut (
      .clk(clk), .rst_n(rst_n), .io_acc_vld(io_acc_vld), .io_acc_port(io_acc_port),
      .ucon_dec_en(ucon_dec_en), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
      .swtmr_expire(swtmr_expire), .ucon_smi_en(ucon_smi_en), .swtmr_smi_en(swtmr_smi_en),
      .gpe0_sts(gpe0_sts), .gpe0_en(gpe0_en), .pm1_sts(pm1_sts),
      .alt_gpi_sts(alt_gpi_sts), .alt_gpi_en(alt_gpi_en), .alt_gpi_route(alt_gpi_route),
      .devtrap_bit0(devtrap_bit0), .rd_data(rd_data), .smi_req(smi_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #800000;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 rd_data", rd_data, 32'h0);
      chk("R1 smi_req", {31'b0, smi_req}, 32'h0);
      rst_n = 1'b1;
      step();
      chk("R1 after release", rd_data, 32'h0);

      // R2 / R3: port window sweep, decode enable off and on
      for (int d = 0; d < 2; d++) begin
         for (int p = 'h5E; p < 'h6A; p++) begin
            logic exp_set;
            exp_set = (d == 1) && (p == 'h62 || p == 'h66);
            io_acc_vld = 1'b1; io_acc_port = 16'(p); ucon_dec_en = d[0];
            step();
            io_acc_vld = 1'b0;
            chk("R2 port decode", {31'b0, rd_data[11]}, {31'b0, exp_set});
            reg_wr_en = 1'b1; reg_wr_data = 32'h0000_0800;
            step();
            reg_wr_en = 1'b0;
            chk("R3 w1c clears bit 11", {31'b0, rd_data[11]}, 32'h0);
         end
      end
      // strobe low must not set
      io_acc_port = 16'h62; ucon_dec_en = 1'b1; io_acc_vld = 1'b0;
      step();
      chk("R2 no strobe", {31'b0, rd_data[11]}, 32'h0);

      // R5: timer sets and holds; R3 write 0 keeps
      swtmr_expire = 1'b1;
      step();
      swtmr_expire = 1'b0;
      chk("R5 timer set", {31'b0, rd_data[6]}, 32'h1);
      repeat (4) step();
      chk("R5 timer holds", {31'b0, rd_data[6]}, 32'h1);
      reg_wr_en = 1'b1; reg_wr_data = 32'hFFFF_FFBF;
      step();
      reg_wr_en = 1'b0;
      chk("R3 write 0 keeps bit 6", {31'b0, rd_data[6]}, 32'h1);
      reg_wr_en = 1'b1; reg_wr_data = 32'h0000_0040;
      step();
      reg_wr_en = 1'b0;
      chk("R3 w1c clears bit 6", {31'b0, rd_data[6]}, 32'h0);

      // R4: collision, set wins, for both sticky bits
      swtmr_expire = 1'b1; io_acc_vld = 1'b1; io_acc_port = 16'h66; ucon_dec_en = 1'b1;
      reg_wr_en = 1'b1; reg_wr_data = 32'h0000_0840;
      step();
      swtmr_expire = 1'b0; io_acc_vld = 1'b0; reg_wr_en = 1'b0;
      chk("R4 set wins bit 11", {31'b0, rd_data[11]}, 32'h1);
      chk("R4 set wins bit 6", {31'b0, rd_data[6]}, 32'h1);
      chk("R6 no enable no request", {31'b0, smi_req}, 32'h0);
      reg_wr_en = 1'b1; reg_wr_data = 32'h0000_0840;
      step();
      reg_wr_en = 1'b0;
      chk("R3 both cleared", rd_data & 32'h0000_0840, 32'h0);

      // R6: request latency for each sticky source
      for (int s = 0; s < 2; s++) begin
         ucon_smi_en = (s == 0); swtmr_smi_en = (s == 1);
         if (s == 0) begin io_acc_vld = 1'b1; io_acc_port = 16'h62; end
         else swtmr_expire = 1'b1;
         step();
         io_acc_vld = 1'b0; swtmr_expire = 1'b0;
         chk("R6 request not before one cycle", {31'b0, smi_req}, 32'h0);
         step();
         chk("R6 request raised", {31'b0, smi_req}, 32'h1);
         reg_wr_en = 1'b1; reg_wr_data = 32'h0000_0840;
         step();
         reg_wr_en = 1'b0;
         chk("R6 request lags clear", {31'b0, smi_req}, 32'h1);
         step();
         chk("R6 request dropped", {31'b0, smi_req}, 32'h0);
      end
      // R6: enable gates the set bit
      ucon_smi_en = 1'b0; swtmr_smi_en = 1'b1;
      io_acc_vld = 1'b1; io_acc_port = 16'h62;
      step(); io_acc_vld = 1'b0; step();
      chk("R6 bit 11 without its enable", {31'b0, smi_req}, 32'h0);
      reg_wr_en = 1'b1; reg_wr_data = 32'h0000_0800;
      step(); reg_wr_en = 1'b0;

      // R8: GPE0 single-bit sweep
      for (int i = 0; i < 32; i++) begin
         logic inc;
         inc = (i == 0 || i == 3 || i == 4 || i == 6 || i == 7 || i == 8 || i == 11 || i == 13);
         gpe0_sts = 32'h1 << i; gpe0_en = 32'hFFFF_FFFF;
         #1;
         chk($sformatf("R8 gpe0 bit %0d enabled", i), {31'b0, rd_data[9]}, {31'b0, inc});
         gpe0_en = ~(32'h1 << i);
         #1;
         chk($sformatf("R8 gpe0 bit %0d disabled", i), {31'b0, rd_data[9]}, 32'h0);
      end
      gpe0_sts = '0; gpe0_en = '0;

      // R9: PM1 single-bit sweep
      for (int i = 0; i < 16; i++) begin
         pm1_sts = 16'h1 << i;
         #1;
         chk($sformatf("R9 pm1 bit %0d", i), {31'b0, rd_data[8]}, {31'b0, (i != 4 && i != 5)});
      end

      // R7: alternate GPI, every gate combination at every position
      for (int i = 0; i < 16; i++) begin
         for (int c = 0; c < 8; c++) begin
            alt_gpi_sts   = c[0] ? (16'h1 << i) : 16'h0;
            alt_gpi_en    = c[1] ? (16'h1 << i) : 16'h0;
            alt_gpi_route = c[2] ? (16'h1 << i) : 16'h0;
            #1;
            chk($sformatf("R7 gpi bit %0d combo %0d", i, c), {31'b0, rd_data[10]},
                {31'b0, (c == 7)});
         end
      end

      // R10: all summaries and device-trap high, sticky clear, no request
      gpe0_sts = '1; gpe0_en = '1; pm1_sts = '1; ucon_smi_en = 1'b1;
      devtrap_bit0 = 1'b1;
      step(); step();
      chk("R10 summaries set", rd_data, 32'h0000_1700);
      chk("R10 no request", {31'b0, smi_req}, 32'h0);

      // R7, R9, R11, R12: writing all ones changes no live or reserved bit
      reg_wr_en = 1'b1; reg_wr_data = 32'hFFFF_FFFF;
      step();
      reg_wr_en = 1'b0;
      chk("R12 write all ones", rd_data, 32'h0000_1700);
      chk("R11 device-trap mirror high", {31'b0, rd_data[12]}, 32'h1);
      devtrap_bit0 = 1'b0; pm1_sts = 16'h0030; alt_gpi_sts = '0; gpe0_sts = 32'hFFFF_0000;
      #1;
      chk("R11 device-trap mirror low", {31'b0, rd_data[12]}, 32'h0);
      chk("R9 excluded bits only", {31'b0, rd_data[8]}, 32'h0);
      chk("R8 upper half only", {31'b0, rd_data[9]}, 32'h0);
      chk("R12 reserved idle", rd_data, 32'h0);

      finish_run();
   end
endmodule